// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs a repeated string instruction in hardware. At a start pulse it takes a source pointer, a destination pointer, an element count, a direction bit and an element size. It also takes an accumulator value, the operation to perform and the repeat-prefix kind. It then steps through memory one element at a time over a synchronous memory port.

Three operations are supported:
- **Copy** reads the element at the source pointer and writes it to the destination pointer.
- **Compare** reads both elements and sets the zero flag when they are equal.
- **Scan** reads the destination element and sets the zero flag when it equals the accumulator.

After each element the count drops by one and both pointers move by the element size. They move up when the direction bit is 0 and down when it is 1. The run ends when the count reaches zero. For compare and scan it can also end early, when the zero flag fails the condition chosen by the prefix kind.

The memory port is synchronous. Read data appears on `mem_rdata` in the cycle after a read request. A write is taken at the clock edge that ends the request cycle. At the end of a run the final pointers, count and zero flag are held on the outputs, and `done` pulses for one cycle.

Top module: `strop_engine`

## Requirements
- R1: After reset the outputs are all zero: `busy`, `done`, `mem_rd`, `mem_wr`, `src_out`, `dst_out`, `cnt_out` and `zf_out`.
- R2: A start with a count of zero processes no element and makes no memory access. `done` is high in the cycle right after the start edge. The pointers are loaded unchanged, and the zero flag keeps its previous value.
- R3: Each processed element lowers the count by one. Both pointers move by the same step: 1 when `word_mode`=0 (byte) and 2 when `word_mode`=1 (16-bit word). They move up when `dir_flag`=0 and down when `dir_flag`=1.
- R4: Copy (`op_kind`=0, and also the unused code 3) reads the source address, then writes that value to the destination address. Byte elements use data bits 7:0 only.
- R5: Compare (`op_kind`=1) reads the source element, then the destination element. It sets the zero flag to 1 when the two are equal, comparing bits 7:0 for bytes and 15:0 for words.
- R6: Scan (`op_kind`=2) reads only the destination element. It sets the zero flag to 1 when the element equals `acc_in`, compared at the element size.
- R7: With the unconditional prefix (`rep_kind`=0, and also the unused code 3), the run always lasts exactly the loaded count, whatever the zero flag does.
- R8: With the repeat-while-equal prefix (`rep_kind`=1), a compare or scan element that leaves the zero flag at 0 ends the run, even if count remains.
- R9: With the repeat-while-not-equal prefix (`rep_kind`=2), a compare or scan element that leaves the zero flag at 1 ends the run.
- R10: A copy never changes the zero flag and is never ended early, under any prefix.
- R11: Each element takes exactly three cycles: a first read, a second cycle (second read for compare), then a third cycle (write for copy). `mem_rd` and `mem_wr` are never high together. `busy` stays high from the cycle after the start edge through the `done` cycle, and `done` is a one-cycle pulse.
- R12: A start pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| op_kind | input | 2 | 0 copy, 1 compare, 2 scan, 3 copy |
| rep_kind | input | 2 | 0 unconditional, 1 while equal, 2 while not equal, 3 unconditional |
| word_mode | input | 1 | 1 selects 16-bit elements, 0 bytes |
| dir_flag | input | 1 | 0 pointers ascend, 1 descend |
| src_in | input | AW | Initial source pointer |
| dst_in | input | AW | Initial destination pointer |
| cnt_in | input | CW | Initial element count |
| acc_in | input | 16 | Scan match value |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_word | output | 1 | Access size, 1 = word |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after the request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| src_out | output | AW | Current source pointer |
| dst_out | output | AW | Current destination pointer |
| cnt_out | output | CW | Current count |
| zf_out | output | 1 | Zero flag |

## Verification
On the last element, the count reaching zero and a failing zero-flag condition can end the run in the same cycle. The bench provokes this with a repeat-while-equal compare whose only mismatch is the final element. It then checks four things: a single `done` pulse three cycles after the last first read, a final count of zero, a cleared zero flag, and no extra memory traffic. A second collision comes from a start pulse injected into the middle of a run. This is judged by the run's cycle trace and final values being identical to an undisturbed run.

// File: rtl/strop_pkg.sv
// Shared encodings for the string operation sequencer.
package strop_pkg;
    localparam int DW = 16;

    typedef enum logic [1:0] {
        OP_COPY = 2'd0,
        OP_CMP  = 2'd1,
        OP_SCAN = 2'd2,
        OP_SPARE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RP_ALL   = 2'd0,
        RP_WHILE_EQ = 2'd1,
        RP_WHILE_NE = 2'd2,
        RP_SPARE = 2'd3
    } rep_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_FINISH,
        ST_END
    } st_e;
endpackage

// File: rtl/strop_ptr_unit.sv
// Pointer and count registers. Loads all three on a run start, and on each
// element step moves both pointers by the element size in the chosen
// direction and lowers the count. Assumes load and step are never together.
module strop_ptr_unit #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          word,
    input  logic          dir,
    input  logic [AW-1:0] src_ld,
    input  logic [AW-1:0] dst_ld,
    input  logic [CW-1:0] cnt_ld,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_dec
);
    logic [AW-1:0] amt;

    // Element size in address units.
    assign amt     = word ? AW'(2) : AW'(1);
    assign cnt_dec = cnt - CW'(1);

    // Register update: load at start, advance at each element end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
            cnt <= '0;
        end else if (load) begin
            src <= src_ld;
            dst <= dst_ld;
            cnt <= cnt_ld;
        end else if (step) begin
            src <= dir ? src - amt : src + amt;
            dst <= dir ? dst - amt : dst + amt;
            cnt <= cnt_dec;
        end
    end
endmodule

// File: rtl/strop_judge.sv
// Combinational element judgement. Forms the new zero flag from the two
// operands of the element just finished and decides whether the run ends.
// Assumes first = first element read, second = data of the second read.
module strop_judge
    import strop_pkg::*;
#(
    parameter int CW = 16
) (
    input  op_e           op,
    input  rep_e          rep,
    input  logic          word,
    input  logic [DW-1:0] first,
    input  logic [DW-1:0] second,
    input  logic [DW-1:0] acc,
    input  logic [CW-1:0] cnt_dec,
    input  logic          zf_cur,
    output logic          zf_next,
    output logic          stop
);
    logic [DW-1:0] mask;
    logic [DW-1:0] lhs;
    logic [DW-1:0] rhs;
    logic          eq;
    logic          flags;
    logic          cond_fail;

    // Operand selection and size-masked equality.
    always_comb begin
        mask  = word ? {DW{1'b1}} : {{(DW-8){1'b0}}, 8'hFF};
        lhs   = (op == OP_SCAN) ? acc : first;
        rhs   = (op == OP_SCAN) ? first : second;
        eq    = ((lhs & mask) == (rhs & mask));
        flags = (op == OP_CMP) || (op == OP_SCAN);
    end

    // Flag result and termination decision.
    always_comb begin
        zf_next   = flags ? eq : zf_cur;
        cond_fail = flags && (((rep == RP_WHILE_EQ) && !eq) ||
                              ((rep == RP_WHILE_NE) && eq));
        stop      = (cnt_dec == '0) || cond_fail;
    end
endmodule

// File: rtl/strop_fsm.sv
// Run sequencer. Latches the run settings at start, walks each element
// through three cycles (first read, second read or capture, finish) and
// drives the memory port. Assumes read data one cycle after the request.
module strop_fsm
    import strop_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_in,
    input  logic [1:0]    rep_in,
    input  logic          word_in,
    input  logic          dir_in,
    input  logic [DW-1:0] acc_in,
    input  logic          cnt_zero,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic [DW-1:0] mem_rdata,
    input  logic          stop,
    input  logic          zf_next,
    output op_e           op_q,
    output rep_e          rep_q,
    output logic          word_q,
    output logic          dir_q,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] first_q,
    output logic          zf_q,
    output logic          load,
    output logic          step,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done
);
    st_e  state;
    logic is_copy;

    assign is_copy = (op_q == OP_COPY) || (op_q == OP_SPARE);
    assign load    = (state == ST_IDLE) && start;
    assign step    = (state == ST_FINISH);

    // State progression through the element cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:   if (start) state <= cnt_zero ? ST_END : ST_FIRST;
                ST_FIRST:  state <= ST_SECOND;
                ST_SECOND: state <= ST_FINISH;
                ST_FINISH: state <= stop ? ST_END : ST_FIRST;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Capture of run settings at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_COPY;
            rep_q  <= RP_ALL;
            word_q <= 1'b0;
            dir_q  <= 1'b0;
            acc_q  <= '0;
        end else if (load) begin
            op_q   <= op_e'(op_in);
            rep_q  <= rep_e'(rep_in);
            word_q <= word_in;
            dir_q  <= dir_in;
            acc_q  <= acc_in;
        end
    end

    // Hold of the first element read.
    always_ff @(posedge clk) begin
        if (!rst_n)                  first_q <= '0;
        else if (state == ST_SECOND) first_q <= mem_rdata;
    end

    // Zero flag update at each element end.
    always_ff @(posedge clk) begin
        if (!rst_n)     zf_q <= 1'b0;
        else if (step)  zf_q <= zf_next;
    end

    // Memory port and status drive.
    always_comb begin
        mem_rd    = (state == ST_FIRST) ||
                    ((state == ST_SECOND) && (op_q == OP_CMP));
        mem_wr    = (state == ST_FINISH) && is_copy;
        mem_word  = word_q;
        mem_addr  = ((state == ST_FIRST) && (op_q != OP_SCAN)) ? src : dst;
        mem_wdata = first_q;
        busy      = (state != ST_IDLE);
        done      = (state == ST_END);
    end
endmodule

// File: rtl/strop_engine.sv
// Top level of the repeated string operation sequencer. Connects the
// sequencer, the pointer/count unit and the element judge.
module strop_engine
    import strop_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op_kind,
    input  logic [1:0]    rep_kind,
    input  logic          word_mode,
    input  logic          dir_flag,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic [15:0]   acc_in,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic          zf_out
);
    op_e           op_q;
    rep_e          rep_q;
    logic          word_q;
    logic          dir_q;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] first_q;
    logic          zf_q;
    logic          zf_next;
    logic          stop;
    logic          load;
    logic          step;
    logic [CW-1:0] cnt_dec;

    strop_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_in(op_kind), .rep_in(rep_kind), .word_in(word_mode),
        .dir_in(dir_flag), .acc_in(acc_in), .cnt_zero(cnt_in == '0),
        .src(src_out), .dst(dst_out), .mem_rdata(mem_rdata),
        .stop(stop), .zf_next(zf_next),
        .op_q(op_q), .rep_q(rep_q), .word_q(word_q), .dir_q(dir_q),
        .acc_q(acc_q), .first_q(first_q), .zf_q(zf_q),
        .load(load), .step(step),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done)
    );

    strop_ptr_unit #(.AW(AW), .CW(CW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .word(word_q), .dir(dir_q),
        .src_ld(src_in), .dst_ld(dst_in), .cnt_ld(cnt_in),
        .src(src_out), .dst(dst_out), .cnt(cnt_out), .cnt_dec(cnt_dec)
    );

    strop_judge #(.CW(CW)) u_judge (
        .op(op_q), .rep(rep_q), .word(word_q),
        .first(first_q), .second(mem_rdata), .acc(acc_q),
        .cnt_dec(cnt_dec), .zf_cur(zf_q),
        .zf_next(zf_next), .stop(stop)
    );

    assign zf_out = zf_q;
endmodule

// File: rtl/strop_engine_chk.sv
// Assertion checker for strop_engine, attached by bind. Observes ports only.
module strop_engine_chk #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [CW-1:0] cnt_in,
    input logic          busy,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] src_out,
    input logic [AW-1:0] dst_out,
    input logic [CW-1:0] cnt_out
);
    assert_rw_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    assert_empty_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && cnt_in == '0) |=> (done && !mem_rd && !mem_wr));

    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cnt_out != $past(cnt_out))
            |-> (cnt_out == $past(cnt_out) - 1'b1));

    assert_pointers_together_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cnt_out != $past(cnt_out))
            |-> ((src_out - $past(src_out)) == (dst_out - $past(dst_out))));

    assert_pointers_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cnt_out == $past(cnt_out))
            |-> ($stable(src_out) && $stable(dst_out)));
endmodule

bind strop_engine strop_engine_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/strop_engine_test.sv
module strop_engine_test;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    op_kind;
    logic [1:0]    rep_kind;
    logic          word_mode;
    logic          dir_flag;
    logic [AW-1:0] src_in;
    logic [AW-1:0] dst_in;
    logic [CW-1:0] cnt_in;
    logic [15:0]   acc_in;
    logic          mem_rd;
    logic          mem_wr;
    logic          mem_word;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata;
    logic          busy;
    logic          done;
    logic [AW-1:0] src_out;
    logic [AW-1:0] dst_out;
    logic [CW-1:0] cnt_out;
    logic          zf_out;

    always #10 clk = ~clk;

    strop_engine #(.AW(AW), .CW(CW)) uut (.*);

    logic [7:0] ram  [0:255];
    logic [7:0] rmem [0:255];

    always @(posedge clk)
        if (mem_rd) mem_rdata <= {ram[8'(mem_addr + 16'd1)], ram[mem_addr[7:0]]};

    typedef struct packed {
        logic        busy;
        logic        done;
        logic        rd;
        logic        wr;
        logic        word;
        logic [15:0] addr;
        logic [15:0] wdata;
    } rec_t;

    rec_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    int   e_src, e_dst, e_cnt;
    bit   e_zf = 0;

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_rd(int a, bit w);
        return w ? {rmem[(a + 1) & 255], rmem[a & 255]} : {8'h00, rmem[a & 255]};
    endfunction

    task automatic put(bit b, bit d, bit rd, bit wr, bit w, int a, logic [15:0] wd);
        rec_t r;
        r.busy = b; r.done = d; r.rd = rd; r.wr = wr; r.word = w;
        r.addr = 16'(a); r.wdata = wd;
        q.push_back(r);
    endtask

    task automatic setb(int a, logic [7:0] v);
        ram[a & 255] = v;
        rmem[a & 255] = v;
    endtask

    // Behavioural expectation: full cycle trace and final values of one run.
    task automatic build(int op, int rep, bit w, bit dir, int s, int d, int c, logic [15:0] acc);
        bit fin = 0;
        e_src = s; e_dst = d; e_cnt = c;
        if (c != 0) begin
            while (!fin) begin
                int st = w ? 2 : 1;
                logic [15:0] m = w ? 16'hFFFF : 16'h00FF;
                logic [15:0] a, b;
                bit eq;
                bit flags = (op == 1) || (op == 2);
                put(1, 0, 1, 0, w, (op == 2) ? e_dst : e_src, 16'h0);
                put(1, 0, op == 1, 0, w, e_dst, 16'h0);
                a = ref_rd((op == 2) ? e_dst : e_src, w);
                b = ref_rd(e_dst, w);
                put(1, 0, 0, !flags, w, e_dst, a & m);
                if (!flags) begin
                    rmem[e_dst & 255] = a[7:0];
                    if (w) rmem[(e_dst + 1) & 255] = a[15:8];
                end
                eq = (op == 2) ? ((acc & m) == (a & m)) : ((a & m) == (b & m));
                if (flags) e_zf = eq;
                e_src = (dir ? e_src - st : e_src + st) & 16'hFFFF;
                e_dst = (dir ? e_dst - st : e_dst + st) & 16'hFFFF;
                e_cnt = e_cnt - 1;
                fin = (e_cnt == 0) || (flags && ((rep == 1 && !eq) || (rep == 2 && eq)));
            end
        end
        put(1, 1, 0, 0, w, 0, 16'h0);
        put(0, 0, 0, 0, w, 0, 16'h0);
    endtask

    // Launch one run, compare every cycle, optionally poke start mid-run.
    task automatic run(string tag, int op, int rep, bit w, bit dir,
                       int s, int d, int c, logic [15:0] acc, int poke);
        int cyc = 0;
        build(op, rep, w, dir, s, d, c, acc);
        @(negedge clk);
        op_kind = 2'(op); rep_kind = 2'(rep); word_mode = w; dir_flag = dir;
        src_in = 16'(s); dst_in = 16'(d); cnt_in = 16'(c); acc_in = acc;
        start = 1'b1;
        while (q.size() > 0) begin
            rec_t r;
            @(negedge clk);
            r = q.pop_front();
            chk({tag, "/R11"}, "busy", 32'(busy), 32'(r.busy));
            chk({tag, "/R11"}, "done", 32'(done), 32'(r.done));
            chk({tag, "/R11"}, "mem_rd", 32'(mem_rd), 32'(r.rd));
            chk({tag, "/R11"}, "mem_wr", 32'(mem_wr), 32'(r.wr));
            if (r.rd || r.wr) begin
                chk(tag, "mem_addr", 32'(mem_addr), 32'(r.addr));
                chk(tag, "mem_word", 32'(mem_word), 32'(r.word));
            end
            if (r.wr)
                chk(tag, "mem_wdata", 32'(mem_wdata & (r.word ? 16'hFFFF : 16'h00FF)), 32'(r.wdata));
            if (r.done) begin
                chk({tag, "/R3"}, "src_out", 32'(src_out), 32'(e_src));
                chk({tag, "/R3"}, "dst_out", 32'(dst_out), 32'(e_dst));
                chk({tag, "/R3"}, "cnt_out", 32'(cnt_out), 32'(e_cnt));
                chk(tag, "zf_out", 32'(zf_out), 32'(e_zf));
            end
            if (mem_wr) begin
                ram[mem_addr[7:0]] = mem_wdata[7:0];
                if (mem_word) ram[8'(mem_addr + 16'd1)] = mem_wdata[15:8];
            end
            if (cyc == poke && q.size() > 2) begin
                start = 1'b1;
                op_kind = 2'd2; rep_kind = 2'd1; cnt_in = 16'd9;
                src_in = 16'h0077; dst_in = 16'h0099; word_mode = ~w;
            end else begin
                start = 1'b0;
            end
            cyc++;
        end
        start = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; op_kind = '0; rep_kind = '0;
        word_mode = 1'b0; dir_flag = 1'b0; src_in = '0; dst_in = '0;
        cnt_in = '0; acc_in = '0;
        for (int i = 0; i < 256; i++) setb(i, 8'(i * 7 + 3));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "mem_rd", 32'(mem_rd), 0);
        chk("R1", "mem_wr", 32'(mem_wr), 0);
        chk("R1", "src_out", 32'(src_out), 0);
        chk("R1", "cnt_out", 32'(cnt_out), 0);
        chk("R1", "zf_out", 32'(zf_out), 0);

        // R2: empty run
        run("R2", 1, 1, 0, 0, 16'h0010, 16'h0040, 0, 16'h0, -1);
        // R4: byte copy ascending
        run("R4", 0, 0, 0, 0, 16'h0010, 16'h00C0, 4, 16'h0, -1);
        // R4: word copy descending
        run("R4", 0, 0, 1, 1, 16'h0030, 16'h00E0, 3, 16'h0, -1);
        // R8/R5: compare while equal, mismatch at third byte
        for (int i = 0; i < 6; i++) setb(16'h40 + i, rmem[16'h10 + i]);
        setb(16'h42, 8'hEE);
        run("R8/R5", 1, 1, 0, 0, 16'h0010, 16'h0040, 6, 16'h0, -1);
        // R10: copy under while-equal prefix with zero flag clear
        run("R10", 0, 1, 0, 0, 16'h0020, 16'h00D0, 3, 16'h0, -1);
        // R7: compare unconditional over differing data
        run("R7", 1, 0, 1, 0, 16'h0050, 16'h0070, 4, 16'h0, -1);
        // R9/R6: byte scan while not equal, hit at fourth element descending
        setb(16'h5D, 8'h5A);
        for (int i = 0; i < 3; i++) setb(16'h60 - i, 8'h11);
        run("R9/R6", 2, 2, 0, 1, 16'h0000, 16'h0060, 6, 16'h005A, -1);
        // R6: word scan while not equal, never found
        run("R6", 2, 2, 1, 0, 16'h0000, 16'h0090, 4, 16'hBEEF, -1);
        // R6/R8: byte scan while equal with upper accumulator bits ignored
        setb(16'hA8, 8'h33); setb(16'hA9, 8'h33);
        run("R6/R8", 2, 1, 0, 0, 16'h0000, 16'h00A8, 2, 16'hFF33, -1);
        // R8/R7: count exhaustion and condition failure on the same element
        for (int i = 0; i < 6; i++) setb(16'hB0 + i, rmem[16'h80 + i]);
        setb(16'hB5, 8'h00); setb(16'h85, 8'h01);
        run("R8/R7", 1, 1, 1, 0, 16'h0080, 16'h00B0, 3, 16'h0, -1);
        // R12: start pokes during a run are ignored
        run("R12", 0, 0, 1, 0, 16'h0008, 16'h00F0, 3, 16'h0, 2);
        run("R12", 3, 3, 0, 0, 16'h0004, 16'h00C8, 2, 16'h0, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R11 watchdog: got hang expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule